// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the command layer of a small serial EEPROM. A byte-level SPI front end reports the falling and rising edges of chip select and every completed byte. It also reports whether bits of an unfinished byte were pending when chip select rose. The sequencer decodes the first byte of each frame as a command and gathers a 16-bit address. It streams array data or status bytes back to the front end, and collects page-write data in a 32-byte staging buffer. It holds the write-enable latch and the non-volatile status bits, and runs a self-timed programming interval whose length is a parameter in clock cycles.

A separate protection unit decides whether a write may proceed. The sequencer shows it the start address of the current write and the stored protect-enable and block-protect bits. The unit answers on a single allowed input, which is sampled when chip select rises. The sequencer places the byte for the front end to shift out on `tx_byte` and raises `tx_en` while the serial output should be driven. When `tx_en` is low the serial output stays high impedance.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset the write-enable latch is clear, `tx_en` is low, `sr_wpen` and `sr_bp` are zero, and a status read returns 0x00.
- R2: A command byte is recognised only when its upper four bits are zero. Bit 3 is ignored, and bits 2:0 select the command: 110 latch-set, 100 latch-clear, 101 status read, 001 status write, 011 array read, 010 array write. Any other byte makes the sequencer ignore the rest of the frame with `tx_en` low until the next frame start.
- R3: The latch-set command sets the write-enable latch and the latch-clear command clears it. The latch is visible as bit 1 of the status byte.
- R4: An array read takes two address bytes, high byte first, and ignores the address bits above the array size. It then presents one data byte per exchanged byte, incrementing the address and rolling over from the last location to location 0.
- R5: An array write or status write received while the write-enable latch is clear is ignored and starts no programming cycle.
- R6: Each page-write data byte advances only the five low address bits. Bytes past the 32nd wrap within the same page, and a later byte overwrites an earlier byte at the same page offset.
- R7: Programming starts only when chip select rises with no partial byte pending and at least one data byte received. Any other end of frame discards the write and leaves the write-enable latch unchanged.
- R8: For TWC_CYCLES cycles after programming starts, a status read returns 0xFF and every other command is ignored.
- R9: The array contents change only when the programming interval ends, all staged bytes at once. The write-enable latch clears at that moment.
- R10: `prot_addr` shows the start address of the current write. When `wr_allowed` is low at the end of the frame, the whole write is dropped and the write-enable latch is left unchanged.
- R11: A status write stores data bit 7 as the protect-enable bit and data bits 3:2 as the block-protect bits, and ignores its other bits. The status byte reads as {protect-enable, 000, block-protect, latch, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse on chip-select fall |
| frame_end | input | 1 | One-cycle pulse on chip-select rise |
| rx_valid | input | 1 | One-cycle pulse: a full byte was exchanged |
| rx_byte | input | 8 | Byte received from the host |
| rx_partial | input | 1 | With frame_end: bits of an unfinished byte were pending |
| wr_allowed | input | 1 | Protection unit verdict for the current write |
| tx_byte | output | 8 | Byte for the front end to shift out next |
| tx_en | output | 1 | Serial output driven when high |
| prot_addr | output | AW | Start address of the current write |
| sr_wpen | output | 1 | Stored protect-enable bit |
| sr_bp | output | 2 | Stored block-protect bits |

## Verification
The bench writes a page starting two bytes below its end and reads back both halves. A design that carried into the upper address bits would land the tail of the data in the next page. A 33-byte burst checks that the first page location holds the last byte. A read started just below the top of the array must continue at location 0 and not stall or saturate. Frames that end mid-byte, frames with no data byte, frames without the latch set and frames the protection unit refuses must all leave the array and the latch untouched; a design that committed on any chip-select rise would corrupt stored data. A read issued during programming must not drive the output, while a status read must show 0xFF and then 0x00 once the latch clears.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_AHI,
    ST_ALO,
    ST_RD,
    ST_WR,
    ST_SRRD,
    ST_SRWR,
    ST_SKIP
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_WRSR  = 3'b001,
    OP_WRITE = 3'b010,
    OP_READ  = 3'b011,
    OP_WRDI  = 3'b100,
    OP_RDSR  = 3'b101,
    OP_WREN  = 3'b110
  } op_code_t;

endpackage

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
  parameter int TWC_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TWC_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (start && !busy) cnt_n = CW'(TWC_CYCLES);
    else if (busy)      cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE = 32,
  localparam int PW = $clog2(PAGE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [PW-1:0]         off,
  input  logic [7:0]            din,
  output logic [PAGE-1:0][7:0]  pg_data,
  output logic [PAGE-1:0]       pg_mask
);
  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic hit;
    assign hit = we && (off == PW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pg_mask[g] <= 1'b0;
      else if (clr) pg_mask[g] <= 1'b0;
      else if (hit) pg_mask[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) pg_data[g] <= din;
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 1024,
  parameter int PAGE  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input  logic                 clk,
  input  logic                 commit,
  input  logic [AW-PW-1:0]     base,
  input  logic [PAGE-1:0][7:0] pg_data,
  input  logic [PAGE-1:0]      pg_mask,
  input  logic [AW-1:0]        raddr,
  output logic [7:0]           rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pg_mask[i]) mem[{base, PW'(i)}] <= pg_data[i];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_cmd_fsm.sv
module eeprom_cmd_fsm
  import eeprom_seq_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_partial,
  input  logic          wr_allowed,
  input  logic          busy,
  input  logic          done,
  output seq_state_t    st,
  output logic          wel,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] start_addr,
  output logic          buf_clr,
  output logic          buf_we,
  output logic          wr_start,
  output logic          pend_sr,
  output logic          sr_wpen,
  output logic [1:0]    sr_bp
);
  seq_state_t    st_n;
  logic [AW-9:0] ahi_q;
  logic [AW-1:0] full_addr;
  logic          wr_cmd_q, have_data_q, wpen_d_q;
  logic [1:0]    bp_d_q;
  logic          byte_in, opc_hit;
  logic [2:0]    op;
  logic          acc_wren, acc_wrdi, acc_read, acc_write, acc_wrsr, acc_rdsr;

  assign byte_in   = rx_valid && !frame_start && !frame_end;
  assign opc_hit   = (st == ST_OPC) && byte_in && (rx_byte[7:4] == 4'h0);
  assign op        = rx_byte[2:0];
  assign acc_rdsr  = opc_hit && (op == OP_RDSR);
  assign acc_wren  = opc_hit && !busy && (op == OP_WREN);
  assign acc_wrdi  = opc_hit && !busy && (op == OP_WRDI);
  assign acc_read  = opc_hit && !busy && (op == OP_READ);
  assign acc_write = opc_hit && !busy && (op == OP_WRITE) && wel;
  assign acc_wrsr  = opc_hit && !busy && (op == OP_WRSR) && wel;
  assign full_addr = {ahi_q, rx_byte};

  assign buf_clr  = acc_write;
  assign buf_we   = (st == ST_WR) && byte_in;
  assign wr_start = frame_end && !rx_partial && have_data_q && wr_allowed && !busy
                    && ((st == ST_WR) || (st == ST_SRWR));

  // next state
  always_comb begin
    st_n = st;
    if (frame_start)    st_n = ST_OPC;
    else if (frame_end) st_n = ST_IDLE;
    else if (byte_in) begin
      case (st)
        ST_OPC: begin
          if (acc_rdsr)                     st_n = ST_SRRD;
          else if (acc_read || acc_write)   st_n = ST_AHI;
          else if (acc_wrsr)                st_n = ST_SRWR;
          else                              st_n = ST_SKIP;
        end
        ST_AHI:  st_n = ST_ALO;
        ST_ALO:  st_n = wr_cmd_q ? ST_WR : ST_RD;
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_n;
  end

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wel <= 1'b0;
    else if (done || acc_wrdi)           wel <= 1'b0;
    else if (acc_wren)                   wel <= 1'b1;
  end

  // command kind and address path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cmd_q   <= 1'b0;
      ahi_q      <= '0;
      addr       <= '0;
      start_addr <= '0;
    end else begin
      if (acc_read || acc_write) wr_cmd_q <= acc_write;
      if ((st == ST_AHI) && byte_in) ahi_q <= rx_byte[AW-9:0];
      if ((st == ST_ALO) && byte_in) begin
        addr       <= full_addr;
        start_addr <= full_addr;
      end else if ((st == ST_RD) && byte_in) begin
        addr <= addr + AW'(1);
      end else if ((st == ST_WR) && byte_in) begin
        addr <= {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
      end
    end
  end

  // data-present flag, status staging and non-volatile status bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_data_q <= 1'b0;
      wpen_d_q    <= 1'b0;
      bp_d_q      <= 2'b00;
      pend_sr     <= 1'b0;
      sr_wpen     <= 1'b0;
      sr_bp       <= 2'b00;
    end else begin
      if (frame_start) have_data_q <= 1'b0;
      else if (byte_in && ((st == ST_WR) || (st == ST_SRWR))) have_data_q <= 1'b1;
      if ((st == ST_SRWR) && byte_in) begin
        wpen_d_q <= rx_byte[7];
        bp_d_q   <= rx_byte[3:2];
      end
      if (wr_start) pend_sr <= (st == ST_SRWR);
      if (done && pend_sr) begin
        sr_wpen <= wpen_d_q;
        sr_bp   <= bp_d_q;
      end
    end
  end
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int PAGE       = 32,
  parameter int TWC_CYCLES = 100000,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_partial,
  input  logic          wr_allowed,
  output logic [7:0]    tx_byte,
  output logic          tx_en,
  output logic [AW-1:0] prot_addr,
  output logic          sr_wpen,
  output logic [1:0]    sr_bp
);
  logic [1:0]           rst_sync;
  logic                 rst_q;
  seq_state_t           st;
  logic                 wel, busy, done, wr_start, pend_sr, buf_clr, buf_we;
  logic [AW-1:0]        addr, start_addr;
  logic [PAGE-1:0][7:0] pg_data;
  logic [PAGE-1:0]      pg_mask;
  logic [7:0]           rdata, status;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  eeprom_cmd_fsm #(.AW(AW), .PW(PW)) i_fsm (
    .clk(clk), .rst_n(rst_q), .frame_start(frame_start), .frame_end(frame_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_partial(rx_partial),
    .wr_allowed(wr_allowed), .busy(busy), .done(done), .st(st), .wel(wel),
    .addr(addr), .start_addr(start_addr), .buf_clr(buf_clr), .buf_we(buf_we),
    .wr_start(wr_start), .pend_sr(pend_sr), .sr_wpen(sr_wpen), .sr_bp(sr_bp)
  );

  eeprom_page_buf #(.PAGE(PAGE)) i_buf (
    .clk(clk), .rst_n(rst_q), .clr(buf_clr | (done & ~pend_sr)), .we(buf_we),
    .off(addr[PW-1:0]), .din(rx_byte), .pg_data(pg_data), .pg_mask(pg_mask)
  );

  eeprom_wr_timer #(.TWC_CYCLES(TWC_CYCLES)) i_tmr (
    .clk(clk), .rst_n(rst_q), .start(wr_start), .busy(busy), .done(done)
  );

  eeprom_array #(.DEPTH(DEPTH), .PAGE(PAGE)) i_mem (
    .clk(clk), .commit(done & ~pend_sr), .base(start_addr[AW-1:PW]),
    .pg_data(pg_data), .pg_mask(pg_mask), .raddr(addr), .rdata(rdata)
  );

  assign status    = busy ? 8'hFF : {sr_wpen, 3'b000, sr_bp, wel, 1'b0};
  assign tx_en     = (st == ST_RD) || (st == ST_SRRD);
  assign tx_byte   = (st == ST_SRRD) ? status : rdata;
  assign prot_addr = start_addr;
endmodule

// File: rtl/eeprom_cmd_seq_chk.sv
module eeprom_cmd_seq_chk
  import eeprom_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_q,
  input seq_state_t st,
  input logic       wel,
  input logic       busy,
  input logic       done,
  input logic       wr_start,
  input logic       frame_end,
  input logic       rx_partial,
  input logic       wr_allowed,
  input logic       sr_wpen,
  input logic [1:0] sr_bp
);
  // R8: while programming, no read, write or address phase is active
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_q)
    busy |-> (st != ST_RD && st != ST_WR && st != ST_SRWR && st != ST_AHI && st != ST_ALO));

  a_r9_wel_clears: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !wel);

  a_r7_start_aligned: assert property (@(posedge clk) disable iff (!rst_q)
    wr_start |-> (frame_end && !rx_partial));

  a_r10_start_allowed: assert property (@(posedge clk) disable iff (!rst_q)
    wr_start |-> wr_allowed);

  a_r5_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_q)
    wr_start |-> wel);

  a_r11_sr_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !done |=> $stable({sr_wpen, sr_bp}));
endmodule

bind eeprom_cmd_seq eeprom_cmd_seq_chk i_chk (
  .clk(clk), .rst_q(rst_q), .st(st), .wel(wel), .busy(busy), .done(done),
  .wr_start(wr_start), .frame_end(frame_end), .rx_partial(rx_partial),
  .wr_allowed(wr_allowed), .sr_wpen(sr_wpen), .sr_bp(sr_bp)
);

// File: tb/test_eeprom_cmd_seq.sv
module test_eeprom_cmd_seq;
  localparam int TWC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, frame_end = 1'b0, rx_valid = 1'b0, rx_partial = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       wr_allowed = 1'b1;
  logic [7:0] tx_byte;
  logic       tx_en;
  logic [9:0] prot_addr;
  logic       sr_wpen;
  logic [1:0] sr_bp;
  int         errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  eeprom_cmd_seq #(.DEPTH(1024), .PAGE(32), .TWC_CYCLES(TWC)) i_eeprom_cmd_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_partial(rx_partial),
    .wr_allowed(wr_allowed), .tx_byte(tx_byte), .tx_en(tx_en),
    .prot_addr(prot_addr), .sr_wpen(sr_wpen), .sr_bp(sr_bp)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fstart();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic fend(logic partial);
    @(negedge clk) begin frame_end = 1'b1; rx_partial = partial; end
    @(negedge clk) begin frame_end = 1'b0; rx_partial = 1'b0; end
  endtask

  task automatic sbyte(logic [7:0] b);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic status_is(string req, logic [7:0] exp);
    fstart();
    sbyte(8'h05);
    chk(req, {23'd0, tx_en, tx_byte}, {23'd0, 1'b1, exp});
    fend(1'b0);
  endtask

  task automatic cmd1(logic [7:0] b);
    fstart(); sbyte(b); fend(1'b0);
  endtask

  task automatic wait_ready();
    repeat (TWC + 5) @(negedge clk);
  endtask

  task automatic page_write(logic [15:0] a, int n, logic [7:0] first, logic [7:0] stepv);
    fstart(); sbyte(8'h02); sbyte(a[15:8]); sbyte(a[7:0]);
    for (int k = 0; k < n; k++) sbyte(first + 8'(k) * stepv);
    fend(1'b0);
  endtask

  task automatic read_start(logic [15:0] a);
    fstart(); sbyte(8'h03); sbyte(a[15:8]); sbyte(a[7:0]);
  endtask

  task automatic read_next(string req, logic [7:0] exp);
    chk(req, {23'd0, tx_en, tx_byte}, {23'd0, 1'b1, exp});
    sbyte(8'h00);
  endtask

  task automatic t_reset();
    chk("R1 tx_en", {31'd0, tx_en}, 32'd0);
    chk("R1 sr bits", {29'd0, sr_wpen, sr_bp}, 32'd0);
    status_is("R1 status", 8'h00);
  endtask

  task automatic t_decode();
    cmd1(8'h0E);                     // bit 3 set, latch-set
    status_is("R2 R3 wren bit3", 8'h02);
    cmd1(8'h04);
    status_is("R3 wrdi", 8'h00);
    fstart(); sbyte(8'h07); sbyte(8'h00); sbyte(8'h00);
    chk("R2 invalid low bits", {31'd0, tx_en}, 32'd0);
    fend(1'b0);
    fstart(); sbyte(8'h13); sbyte(8'h00);
    chk("R2 upper nibble", {31'd0, tx_en}, 32'd0);
    fend(1'b0);
    fstart(); sbyte(8'h0D);
    chk("R2 rdsr bit3", {23'd0, tx_en, tx_byte}, {23'd0, 1'b1, 8'h00});
    fend(1'b0);
  endtask

  task automatic t_page_wrap();
    cmd1(8'h06);
    page_write(16'h001E, 4, 8'h11, 8'h11);
    status_is("R8 busy ff", 8'hFF);
    wait_ready();
    status_is("R9 wel cleared", 8'h00);
    read_start(16'h0000);
    read_next("R6 wrap off0", 8'h33);
    read_next("R6 wrap off1", 8'h44);
    fend(1'b0);
    read_start(16'h001E);
    read_next("R6 off30", 8'h11);
    read_next("R6 off31", 8'h22);
    fend(1'b0);
  endtask

  task automatic t_overflow();
    cmd1(8'h06);
    page_write(16'h0040, 33, 8'h80, 8'h01);
    wait_ready();
    read_start(16'h0040);
    read_next("R6 overwrite", 8'hA0);
    read_next("R6 next", 8'h81);
    read_next("R6 next2", 8'h82);
    fend(1'b0);
  endtask

  task automatic t_rollover();
    cmd1(8'h06);
    page_write(16'h03FE, 2, 8'h5A, 8'h4B);
    wait_ready();
    read_start(16'hFFFE);            // upper bits don't-care
    read_next("R4 top-1", 8'h5A);
    read_next("R4 top", 8'hA5);
    read_next("R4 roll to 0", 8'h33);
    fend(1'b0);
  endtask

  task automatic t_busy_ignore();
    cmd1(8'h06);
    page_write(16'h0100, 1, 8'h77, 8'h00);
    fstart(); sbyte(8'h03); sbyte(8'h01); sbyte(8'h00);
    chk("R8 read ignored", {31'd0, tx_en}, 32'd0);
    fend(1'b0);
    status_is("R8 busy during", 8'hFF);
    read_start(16'h0100);
    chk("R9 not yet written", {31'd0, tx_en}, 32'd0);
    fend(1'b0);
    wait_ready();
    read_start(16'h0100);
    read_next("R9 committed", 8'h77);
    fend(1'b0);
  endtask

  task automatic t_no_wel();
    page_write(16'h0100, 1, 8'h99, 8'h00);
    status_is("R5 not busy", 8'h00);
    read_start(16'h0100);
    read_next("R5 unchanged", 8'h77);
    fend(1'b0);
  endtask

  task automatic t_unaligned();
    cmd1(8'h06);
    fstart(); sbyte(8'h02); sbyte(8'h01); sbyte(8'h00); sbyte(8'h55);
    fend(1'b1);
    status_is("R7 partial dropped wel kept", 8'h02);
    fstart(); sbyte(8'h02); sbyte(8'h01); sbyte(8'h00);
    fend(1'b0);
    status_is("R7 no data byte", 8'h02);
    read_start(16'h0100);
    read_next("R7 unchanged", 8'h77);
    fend(1'b0);
  endtask

  task automatic t_protect();
    wr_allowed = 1'b0;
    fstart(); sbyte(8'h02); sbyte(8'h01); sbyte(8'h00); sbyte(8'h66);
    chk("R10 prot_addr", {22'd0, prot_addr}, 32'h100);
    fend(1'b0);
    wr_allowed = 1'b1;
    status_is("R10 dropped wel kept", 8'h02);
    read_start(16'h0100);
    read_next("R10 unchanged", 8'h77);
    fend(1'b0);
  endtask

  task automatic t_wrsr();
    fstart(); sbyte(8'h01); sbyte(8'hFF); fend(1'b0);
    status_is("R11 busy", 8'hFF);
    wait_ready();
    chk("R11 sr outputs", {29'd0, sr_wpen, sr_bp}, 32'h7);
    status_is("R11 layout", 8'h8C);
    cmd1(8'h06);
    wr_allowed = 1'b0;
    fstart(); sbyte(8'h01); sbyte(8'h00); fend(1'b0);
    wr_allowed = 1'b1;
    status_is("R10 sr blocked", 8'h8E);
    fstart(); sbyte(8'h01); sbyte(8'h00); fend(1'b0);
    wait_ready();
    status_is("R11 cleared", 8'h00);
    fstart(); sbyte(8'h01); sbyte(8'h8C); fend(1'b0);
    wait_ready();
    chk("R5 wrsr without wel", {29'd0, sr_wpen, sr_bp}, 32'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_decode();
    t_page_wrap();
    t_overflow();
    t_rollover();
    t_busy_ignore();
    t_no_wel();
    t_unaligned();
    t_protect();
    t_wrsr();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end
endmodule